// File: doc/BRIEF.md
# Reloadable 16/8-bit PWM Timer

This block is one decrementing timer channel that generates an unbroken train of pulses whose active width is programmable. Two framing modes are available. In the wide mode a single 16-bit value sets how many count-source ticks the output stays active, inside a fixed frame of 65535 ticks. In the split mode the high byte sets the active width in units and the low byte acts as a prescaler that stretches each unit to m+1 ticks, inside a frame of 255 units.

Counting starts from software alone, or from software plus a selected trigger. The trigger can be a synchronized rising edge on an external pin, a strobe from a shared reference timer, or a strobe from either adjacent channel. After counting has begun, further triggers do nothing. The count source arrives as a clock enable. A write always lands in the reload register, and the counters pick it up at the start of the next frame. An interrupt strobe marks each end of an active pulse, and the output level can be inverted.

Top module: `pwmTimer`

## Requirements
- R1: After reset, with normal polarity, pwmOut is low, irq is low and rdData is zero.
- R2: With trigSel = 00 (software only), setting startBit begins counting, and pwmOut becomes active within 3 clocks when cntEn is held high.
- R3: With mode16 = 1 and register value n, the output is active for exactly n cntEn ticks in each frame of 65535 cntEn ticks. Clocks with cntEn low do not advance the timer.
- R4: With mode16 = 0, wrData[15:8] = n and wrData[7:0] = m, the output is active for n×(m+1) cntEn ticks in each frame of 255×(m+1) cntEn ticks.
- R5: trigSel selects the start trigger: 01 = rising edge of extPin (through a two-flop synchronizer), 10 = tmrB2Strobe, 11 = nbrLoStrobe or nbrHiStrobe. While startBit is 1 and the selected trigger has not arrived, the output stays inactive, and strobes from unselected sources do not start the timer.
- R6: Triggers that arrive while counting change neither pulse width nor frame length.
- R7: A write while counting leaves the current frame unchanged and takes effect from the next frame. A write while stopped takes effect from the first frame.
- R8: Clearing startBit makes the output inactive on the next clock, and no irq follows until counting restarts.
- R9: irq is a one-clock pulse raised in the first cycle the output turns inactive at the natural end of each active pulse.
- R10: With invertOut = 1 the output level is inverted, so pwmOut is high while the timer is stopped.
- R11: A width value n = 0 keeps the output inactive for whole frames and raises no irq.
- R12: rdData reads as zero at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Write data (width value, or {n, m} in split mode) |
| rdData | output | 16 | Read data, fixed zero |
| startBit | input | 1 | Start (1) / stop (0) control |
| trigSel | input | 2 | Start trigger selection |
| extPin | input | 1 | Asynchronous external trigger pin |
| tmrB2Strobe | input | 1 | Reference timer overflow strobe |
| nbrLoStrobe | input | 1 | Lower adjacent channel overflow strobe |
| nbrHiStrobe | input | 1 | Higher adjacent channel overflow strobe |
| mode16 | input | 1 | 1 = wide 16-bit frame, 0 = prescaled 8-bit frame |
| invertOut | input | 1 | Output polarity inversion |
| cntEn | input | 1 | Count-source tick enable |
| pwmOut | output | 1 | PWM pulse output |
| irq | output | 1 | End-of-pulse interrupt strobe |

## Verification
The hardest situations to reach from the ports are a register write or a trigger strobe that lands in the middle of a running frame, because the effect must be absent in the current frame and present only in the next one. The stimulus waits for an observed rising edge of the output and then issues the write, or a burst of strobes, while the pulse is still active. A bench monitor measures every high time and period in cntEn ticks, and cntEn is randomized from a fixed seed, so tick counting and wall-clock timing are kept apart.

// File: rtl/pwmTimerPkg.sv
package pwmTimerPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } runState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic run;    // counters may advance this cycle
    logic clear;  // force counters and output to the idle state
  } ctlStrobes_t;

  localparam logic [1:0] TRIG_SOFT = 2'b00;
  localparam logic [1:0] TRIG_PIN  = 2'b01;
  localparam logic [1:0] TRIG_REF  = 2'b10;
  localparam logic [1:0] TRIG_ADJ  = 2'b11;

endpackage

// File: rtl/pwmTimerCtrl.sv
module pwmTimerCtrl
  import pwmTimerPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startBit,
  input  logic [1:0]  trigSel,
  input  logic        extPin,
  input  logic        tmrB2Strobe,
  input  logic        nbrLoStrobe,
  input  logic        nbrHiStrobe,
  output ctlStrobes_t ctl
);

  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] pinShift;
  logic            pinEdge;
  logic            trigHit;
  runState_t       state, stateNext;

  // synchronizer plus one extra stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinShift <= '0;
    else       pinShift <= {pinShift[SH_W-2:0], extPin};
  end

  assign pinEdge = pinShift[SH_W-2] & ~pinShift[SH_W-1];

  always_comb begin
    unique case (trigSel)
      TRIG_PIN: trigHit = pinEdge;
      TRIG_REF: trigHit = tmrB2Strobe;
      TRIG_ADJ: trigHit = nbrLoStrobe | nbrHiStrobe;
      default:  trigHit = 1'b0;
    endcase
  end

  always_comb begin
    stateNext = state;
    if (!startBit) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (trigSel == TRIG_SOFT || trigHit) stateNext = ST_RUN;
          else                                 stateNext = ST_WAIT;
        end
        ST_WAIT: if (trigHit) stateNext = ST_RUN;
        default: stateNext = ST_RUN;  // running: triggers ignored
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign ctl.run   = (state == ST_RUN) && startBit;
  assign ctl.clear = !ctl.run;

endmodule

// File: rtl/pwmTimerDatapath.sv
module pwmTimerDatapath
  import pwmTimerPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              cntEn,
  input  logic              mode16,
  input  logic              invertOut,
  input  logic              wrEn,
  input  logic [CNT_W-1:0]  wrData,
  output logic              pwmOut,
  output logic              irq
);

  localparam logic [CNT_W-1:0]  FRAME_WIDE  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]  FRAME_SPLIT = {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [CNT_W-1:0]  CNT_ONE     = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [HALF_W-1:0] PRE_ONE     = {{(HALF_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0]  reloadReg;
  logic [CNT_W-1:0]  widthCnt;
  logic [CNT_W-1:0]  frameCnt;
  logic [HALF_W-1:0] preCnt;
  logic [HALF_W-1:0] preHold;

  logic [CNT_W-1:0]  widthLoad;
  logic [CNT_W-1:0]  frameLoad;
  logic [HALF_W-1:0] preLoad;
  logic              unitTick;
  logic              frameStart;

  // writes always go to the reload register; counters take it at frame start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     reloadReg <= '0;
    else if (wrEn) reloadReg <= wrData;
  end

  assign widthLoad  = mode16 ? reloadReg
                             : {{(CNT_W-HALF_W){1'b0}}, reloadReg[CNT_W-1 -: HALF_W]};
  assign frameLoad  = (mode16 ? FRAME_WIDE : FRAME_SPLIT) - CNT_ONE;
  assign preLoad    = mode16 ? '0 : reloadReg[HALF_W-1:0];
  assign unitTick   = cntEn && (mode16 || preCnt == '0);
  assign frameStart = ctl.run && unitTick && (frameCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCnt <= '0;
      frameCnt <= '0;
      preCnt   <= '0;
      preHold  <= '0;
      irq      <= 1'b0;
    end else if (ctl.clear) begin
      widthCnt <= '0;
      frameCnt <= '0;
      preCnt   <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (frameStart) begin
        widthCnt <= widthLoad;
        frameCnt <= frameLoad;
        preCnt   <= preLoad;
        preHold  <= preLoad;
      end else begin
        if (cntEn && !mode16)
          preCnt <= (preCnt == '0) ? preHold : preCnt - PRE_ONE;
        if (unitTick) begin
          frameCnt <= frameCnt - CNT_ONE;
          if (widthCnt != '0) begin
            widthCnt <= widthCnt - CNT_ONE;
            if (widthCnt == CNT_ONE) irq <= 1'b1;
          end
        end
      end
    end
  end

  assign pwmOut = invertOut ^ (widthCnt != '0);

endmodule

// File: rtl/pwmTimer.sv
module pwmTimer
  import pwmTimerPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int HALF_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  logic              startBit,
  input  logic [1:0]        trigSel,
  input  logic              extPin,
  input  logic              tmrB2Strobe,
  input  logic              nbrLoStrobe,
  input  logic              nbrHiStrobe,
  input  logic              mode16,
  input  logic              invertOut,
  input  logic              cntEn,
  output logic              pwmOut,
  output logic              irq
);

  ctlStrobes_t ctl;

  pwmTimerCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .startBit    (startBit),
    .trigSel     (trigSel),
    .extPin      (extPin),
    .tmrB2Strobe (tmrB2Strobe),
    .nbrLoStrobe (nbrLoStrobe),
    .nbrHiStrobe (nbrHiStrobe),
    .ctl         (ctl)
  );

  pwmTimerDatapath #(.CNT_W(CNT_W), .HALF_W(HALF_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cntEn     (cntEn),
    .mode16    (mode16),
    .invertOut (invertOut),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .pwmOut    (pwmOut),
    .irq       (irq)
  );

  assign rdData = '0;

endmodule

// File: rtl/pwmTimerChecker.sv
module pwmTimerChecker (
  input logic clk,
  input logic rstN,
  input logic startBit,
  input logic cntEn,
  input logic invertOut,
  input logic pwmOut,
  input logic irq
);

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);  // R9

  AST_IRQ_AT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((pwmOut == invertOut) && ($past(pwmOut) != $past(invertOut))));  // R9

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !startBit |=> ((pwmOut == invertOut) && !irq));  // R8

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && startBit) |=> ((pwmOut ^ invertOut) == $past(pwmOut ^ invertOut)));  // R3

endmodule

bind pwmTimer pwmTimerChecker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .startBit  (startBit),
  .cntEn     (cntEn),
  .invertOut (invertOut),
  .pwmOut    (pwmOut),
  .irq       (irq)
);

// File: tb/tb_pwmTimer.sv
`timescale 1ns/1ps
module tb_pwmTimer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        startBit = 1'b0;
  logic [1:0]  trigSel = 2'b00;
  logic        extPin = 1'b0;
  logic        tmrB2Strobe = 1'b0;
  logic        nbrLoStrobe = 1'b0;
  logic        nbrHiStrobe = 1'b0;
  logic        mode16 = 1'b0;
  logic        invertOut = 1'b0;
  logic        cntEn = 1'b0;
  logic        pwmOut;
  logic        irq;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  // bench-side stimulus controls
  bit enRandom = 1'b0;
  bit adjBurst = 1'b0;

  // monitor state
  bit prevAct = 1'b0;
  int rises = 0, falls = 0, irqCount = 0, irqStray = 0;
  int hiCnt = 0, perCnt = 0, lastHigh = -1, lastPeriod = -1;

  pwmTimer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .startBit(startBit), .trigSel(trigSel), .extPin(extPin),
    .tmrB2Strobe(tmrB2Strobe), .nbrLoStrobe(nbrLoStrobe), .nbrHiStrobe(nbrHiStrobe),
    .mode16(mode16), .invertOut(invertOut), .cntEn(cntEn),
    .pwmOut(pwmOut), .irq(irq)
  );

  always #2 clk = ~clk;

  // count-source enable and trigger burst driver, changes just after the edge
  always @(posedge clk) begin
    #1;
    cntEn = enRandom ? ($urandom_range(1, 0) == 1) : 1'b1;
    nbrHiStrobe = adjBurst ? ($urandom_range(1, 0) == 1) : 1'b0;
  end

  // monitor: measures active widths and periods in cntEn ticks
  always @(negedge clk) begin
    bit act;
    cycles++;
    act = pwmOut ^ invertOut;
    if (act && !prevAct) begin lastPeriod = perCnt; perCnt = 0; hiCnt = 0; rises++; end
    if (!act && prevAct) begin lastHigh = hiCnt; falls++; end
    if (cntEn) begin perCnt++; if (act) hiCnt++; end
    if (irq) begin
      irqCount++;
      if (!(prevAct && !act)) irqStray++;
    end
    prevAct = act;
  end

  // watchdog
  initial begin
    wait (cycles > 190000);
    testsFailed++;
    $display("FAIL watchdog: actual cycles=%0d expected <190000", cycles);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic writeReg(input logic [15:0] v);
    @(posedge clk); #1;
    wrEn = 1'b1; wrData = v;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic stopTimer();
    @(posedge clk); #1;
    startBit = 1'b0;
    tick(3);
  endtask

  task automatic startTimer();
    @(posedge clk); #1;
    startBit = 1'b1;
  endtask

  task automatic waitRises(input int target, input int limit);
    for (int i = 0; i < limit && rises < target; i++) @(negedge clk);
  endtask

  task automatic waitFalls(input int target, input int limit);
    for (int i = 0; i < limit && falls < target; i++) @(negedge clk);
  endtask

  function automatic int expHigh(input int n, input int m, input bit wide);
    return wide ? n : n * (m + 1);
  endfunction

  function automatic int expPeriod(input int m, input bit wide);
    return wide ? 65535 : 255 * (m + 1);
  endfunction

  initial begin
    int base, irqBase, fallBase, n, m;
    void'($urandom(32'd4711));

    // R1 / R12: reset state
    tick(3);
    @(negedge clk);
    check(pwmOut == 1'b0, "R1 pwmOut at reset", pwmOut, 0);
    check(irq == 1'b0, "R1 irq at reset", irq, 0);
    check(rdData == 16'h0, "R1 rdData at reset", rdData, 0);
    rstN = 1'b1;
    tick(2);

    // R2: software start
    mode16 = 1'b0;
    writeReg({8'd3, 8'd0});
    base = rises;
    startTimer();
    tick(3);
    @(negedge clk);
    check(rises == base + 1, "R2 software start active", rises - base, 1);
    stopTimer();

    // R3: wide mode, n = 5, full-rate source
    mode16 = 1'b1;
    writeReg(16'd5);
    base = rises;
    startTimer();
    waitRises(base + 2, 70000);
    check(lastHigh == expHigh(5, 0, 1), "R3 wide active ticks", lastHigh, 5);
    check(lastPeriod == expPeriod(0, 1), "R3 wide frame ticks", lastPeriod, 65535);
    stopTimer();

    // R3: wide mode, random n, gated source
    enRandom = 1'b1;
    n = $urandom_range(200, 2);
    writeReg(16'(n));
    fallBase = falls;
    startTimer();
    waitFalls(fallBase + 1, 2000);
    check(lastHigh == expHigh(n, 0, 1), "R3 wide width with gated cntEn", lastHigh, n);
    stopTimer();

    // R4: split mode, random n and m, gated source
    mode16 = 1'b0;
    for (int k = 0; k < 5; k++) begin
      n = $urandom_range(254, 1);
      m = $urandom_range(3, 0);
      writeReg({8'(n), 8'(m)});
      base = rises;
      startTimer();
      waitRises(base + 2, 9000);
      check(lastHigh == expHigh(n, m, 0), "R4 split active ticks", lastHigh, expHigh(n, m, 0));
      check(lastPeriod == expPeriod(m, 0), "R4 split frame ticks", lastPeriod, expPeriod(m, 0));
      stopTimer();
    end
    enRandom = 1'b0;

    // R5: pin trigger, unselected strobes ignored
    writeReg({8'd4, 8'd0});
    trigSel = 2'b01;
    base = rises;
    startTimer();
    tick(5);
    tmrB2Strobe = 1'b1; nbrLoStrobe = 1'b1; tick(1);
    tmrB2Strobe = 1'b0; nbrLoStrobe = 1'b0; tick(30);
    check(rises == base, "R5 pin mode ignores strobes", rises - base, 0);
    extPin = 1'b1;
    tick(8);
    check(rises == base + 1, "R5 pin edge starts", rises - base, 1);
    stopTimer();
    extPin = 1'b0;

    // R5: reference strobe select
    trigSel = 2'b10;
    base = rises;
    startTimer();
    tick(3);
    nbrLoStrobe = 1'b1; tick(1); nbrLoStrobe = 1'b0;
    extPin = 1'b1; tick(10); extPin = 1'b0;
    check(rises == base, "R5 ref mode ignores others", rises - base, 0);
    tmrB2Strobe = 1'b1; tick(1); tmrB2Strobe = 1'b0;
    tick(4);
    check(rises == base + 1, "R5 ref strobe starts", rises - base, 1);
    stopTimer();

    // R5: adjacent strobe select
    trigSel = 2'b11;
    base = rises;
    startTimer();
    tick(3);
    tmrB2Strobe = 1'b1; tick(1); tmrB2Strobe = 1'b0; tick(10);
    check(rises == base, "R5 adjacent mode ignores ref", rises - base, 0);
    nbrLoStrobe = 1'b1; tick(1); nbrLoStrobe = 1'b0;
    tick(4);
    check(rises == base + 1, "R5 adjacent strobe starts", rises - base, 1);

    // R6: keep striking adjacent strobes while counting
    stopTimer();
    writeReg({8'd10, 8'd1});
    base = rises;
    startTimer();
    tick(1);
    nbrLoStrobe = 1'b1; tick(1); nbrLoStrobe = 1'b0;
    waitRises(base + 1, 50);
    adjBurst = 1'b1;
    waitRises(base + 3, 3000);
    adjBurst = 1'b0;
    check(lastHigh == expHigh(10, 1, 0), "R6 width under triggers", lastHigh, 20);
    check(lastPeriod == expPeriod(1, 0), "R6 frame under triggers", lastPeriod, 510);
    stopTimer();
    trigSel = 2'b00;

    // R7 / R9: write while counting
    writeReg({8'd20, 8'd0});
    base = rises;
    fallBase = falls;
    irqBase = irqCount;
    startTimer();
    waitRises(base + 1, 20);
    writeReg({8'd60, 8'd0});
    check(rdData == 16'h0, "R12 rdData after write", rdData, 0);
    waitFalls(fallBase + 1, 400);
    check(lastHigh == 20, "R7 current frame unchanged", lastHigh, 20);
    waitFalls(fallBase + 2, 400);
    check(lastHigh == 60, "R7 next frame updated", lastHigh, 60);
    check(irqCount - irqBase == 2, "R9 one irq per fall", irqCount - irqBase, 2);
    check(irqStray == 0, "R9 irq only at pulse end", irqStray, 0);

    // R8: stop in the middle of a pulse
    stopTimer();
    writeReg({8'd100, 8'd0});
    base = rises;
    startTimer();
    waitRises(base + 1, 20);
    tick(10);
    irqBase = irqCount;
    startBit = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check((pwmOut ^ invertOut) == 1'b0, "R8 inactive after stop", pwmOut, 0);
    tick(300);
    check(irqCount == irqBase, "R8 no irq after stop", irqCount - irqBase, 0);

    // R10: inverted polarity
    invertOut = 1'b1;
    tick(1);
    @(negedge clk);
    check(pwmOut == 1'b1, "R10 stopped output high", pwmOut, 1);
    writeReg({8'd7, 8'd2});
    fallBase = falls;
    startTimer();
    waitFalls(fallBase + 1, 200);
    check(lastHigh == 21, "R10 inverted active width", lastHigh, 21);
    stopTimer();
    invertOut = 1'b0;
    tick(1);

    // R11: zero width
    writeReg({8'd0, 8'd1});
    base = rises;
    irqBase = irqCount;
    startTimer();
    tick(1200);
    check(rises == base, "R11 zero width never active", rises - base, 0);
    check(irqCount == irqBase, "R11 zero width no irq", irqCount - irqBase, 0);
    stopTimer();

    check(irqStray == 0, "R9 final stray irq count", irqStray, 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule